// File: doc/BRIEF.md
# Three-Bus Processor Datapath

This block is the register-transfer datapath of a small 32-bit load/store processor. It has no sequencer of its own. An external control word picks, each cycle, which source drives each of three internal buses, which function the ALU performs, and which storage elements capture a value at the next rising clock edge. The three buses are a first operand bus, a second operand bus and a result bus. The storage elements are a 256-entry register file with two read ports and one write port, a program counter, a latched set of condition flags, and an instruction register. On the memory side there are four more: an address latch, a data-in latch, a displacement latch, and a gated write-data driver.

The instruction register splits its word into four fixed fields: opcode in bits 31:24, a destination/third field in bits 23:16, a first source field in bits 15:8 and a second source field in bits 7:0. These fields act as register addresses. The low field can also act as a signed 8-bit immediate. The low nibble of the third field is a condition mask, which is tested against the latched flags and reported back to the controller.

Top module: `tri_bus_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the condition flags, the instruction register and the memory-side latches to zero.
- R2: Read port 1 is addressed by the instruction field in bits 15:8 and drives `op1_bus` when `op1_en[0]` is set. When `rf_write` is high at a clock edge, the result latch is written into the entry addressed by bits 23:16.
- R3: Read port 2 is addressed by bits 7:0 when `a2_from_r3` is 0, and by bits 23:16 when it is 1. Port 2 drives `op2_bus` when `op2_en[0]` is set.
- R4: When `op2_en[1]` is set, `op2_bus` carries the 8-bit field in bits 7:0, with its bit 7 copied into bits 31:8.
- R5: The program counter drives `op1_bus` when `op1_en[1]` is set. It loads `res_bus` when `pc_load` is high at a clock edge, and holds its value otherwise.
- R6: When `res_en[0]` is set, `res_bus` carries the ALU output of op1 and op2 for `alu_func`. The codes are 0 add, 1 subtract (op1-op2), 2 AND, 3 OR, 4 XOR, 5 op1 AND NOT op2, 6 pass op1, and any other code passes op2.
- R7: When `cc_load` is high, the flags are captured. V is signed overflow for add and subtract and 0 for all other functions. N is result bit 31. Z is set when the result is zero. The flags hold while `cc_load` is low.
- R8: With mask = instruction bits 19:16, `cond_match` = (any of V, N, Z selected by mask bits 2, 1, 0 is set) XOR mask bit 3.
- R9: `addr_load` captures `res_bus` into `mem_addr`. `din_load` captures `mem_rdata`, which drives `res_bus` when `res_en[1]` is set. `disp_load` captures `mem_rdata`, which drives `op2_bus` when `op2_en[2]` is set. `mem_wdata` equals `op2_bus` when `dout_en` is high and is zero otherwise.
- R10: A bus with no source enabled reads zero. At most one source enable per bus may be active in any cycle.
- R11: `ir_load` captures `mem_rdata` into the instruction register, and `opcode` shows its bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 32 | Word read from memory |
| ir_load | input | 1 | Capture instruction |
| din_load | input | 1 | Capture data-in latch |
| disp_load | input | 1 | Capture displacement latch |
| addr_load | input | 1 | Capture address latch from result bus |
| op1_en | input | 2 | op1 sources: bit0 port 1, bit1 PC |
| op2_en | input | 3 | op2 sources: bit0 port 2, bit1 immediate, bit2 displacement |
| res_en | input | 2 | result sources: bit0 ALU, bit1 data-in latch |
| a2_from_r3 | input | 1 | Port 2 address from bits 23:16 |
| alu_func | input | 4 | ALU function code |
| cc_load | input | 1 | Capture flags |
| pc_load | input | 1 | Load PC from result bus |
| res_latch_load | input | 1 | Capture result bus for write-back |
| rf_write | input | 1 | Write result latch to register file |
| dout_en | input | 1 | Drive op2 onto write data |
| op1_bus | output | 32 | First operand bus |
| op2_bus | output | 32 | Second operand bus |
| res_bus | output | 32 | Result bus |
| mem_addr | output | 32 | Address latch |
| mem_wdata | output | 32 | Gated write data |
| opcode | output | 8 | Instruction bits 31:24 |
| cond_match | output | 1 | Condition test result |

## Verification
The ALU is driven with operand pairs chosen to tell the flags apart. A positive add that overflows sets V and N but not Z. Subtracting equal values sets only Z. A negative subtract has no overflow. Logic functions on values with the top bit set must leave V clear. Each flag is then read back through a single-bit mask and its inverted form, so a swapped flag position or a missing inversion shows up. The port-2 address switch is tried with two different words in the r2-named and r3-named registers, so a wrong selection returns the wrong word. The immediate is tried with bit 7 both set and clear, which separates sign extension from zero extension.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int XLEN    = 32;
    localparam int FIELD_W = 8;
    localparam int MASK_W  = 4;
    localparam int FN_W    = 4;

    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        logic [FIELD_W-1:0] opcode;
        logic [FIELD_W-1:0] rc;
        logic [FIELD_W-1:0] ra;
        logic [FIELD_W-1:0] rb;
    } instr_t;

    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_AND  = 4'd2,
        FN_OR   = 4'd3,
        FN_XOR  = 4'd4,
        FN_ANDN = 4'd5,
        FN_PASSA = 4'd6,
        FN_PASSB = 4'd7
    } alu_fn_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
    } flags_t;

    function automatic word_t sext_field(input logic [FIELD_W-1:0] f);
        return {{(XLEN-FIELD_W){f[FIELD_W-1]}}, f};
    endfunction

endpackage

// File: rtl/dp_bus_mux.sv
module dp_bus_mux #(
    parameter int N = 2,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   en,
    input  logic [N*W-1:0] src,
    output logic [W-1:0]   bus
);
    logic [W-1:0] gated [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_gate
        assign gated[gi] = src[gi*W +: W] & {W{en[gi]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | gated[i];
        end
    end

    // R10: only one source may own the bus in a cycle
    assert_one_source_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en));

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr1,
    input  logic [AW-1:0] raddr2,
    output logic [W-1:0]  rdata1,
    output logic [W-1:0]  rdata2
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata1 = cells[raddr1];
    assign rdata2 = cells[raddr2];

    // R2: a written word is visible on port 1 in the following cycle
    assert_write_then_read_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> ((raddr1 != $past(waddr)) || (rdata1 == $past(wdata))));

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
(
    input  alu_fn_e fn,
    input  word_t   a,
    input  word_t   b,
    output word_t   y,
    output flags_t  fl
);
    word_t sum;
    word_t diff;
    logic  v_add;
    logic  v_sub;

    assign sum   = a + b;
    assign diff  = a - b;
    assign v_add = (a[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
    assign v_sub = (a[XLEN-1] != b[XLEN-1]) && (diff[XLEN-1] != a[XLEN-1]);

    always_comb begin
        fl.v = 1'b0;
        unique case (fn)
            FN_ADD:   begin y = sum;  fl.v = v_add; end
            FN_SUB:   begin y = diff; fl.v = v_sub; end
            FN_AND:   y = a & b;
            FN_OR:    y = a | b;
            FN_XOR:   y = a ^ b;
            FN_ANDN:  y = a & ~b;
            FN_PASSA: y = a;
            default:  y = b;
        endcase
        fl.n = y[XLEN-1];
        fl.z = (y == '0);
    end

endmodule

// File: rtl/dp_cond.sv
module dp_cond
    import dp_pkg::*;
(
    input  flags_t            cc,
    input  logic [MASK_W-1:0] mask,
    output logic              match
);
    logic any_sel;

    assign any_sel = |(mask[2:0] & {cc.v, cc.n, cc.z});
    assign match   = any_sel ^ mask[3];

endmodule

// File: rtl/tri_bus_datapath.sv
module tri_bus_datapath
    import dp_pkg::*;
#(
    parameter int DATA_W = dp_pkg::XLEN,
    parameter int RF_AW  = dp_pkg::FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              ir_load,
    input  logic              din_load,
    input  logic              disp_load,
    input  logic              addr_load,
    input  logic [1:0]        op1_en,
    input  logic [2:0]        op2_en,
    input  logic [1:0]        res_en,
    input  logic              a2_from_r3,
    input  logic [3:0]        alu_func,
    input  logic              cc_load,
    input  logic              pc_load,
    input  logic              res_latch_load,
    input  logic              rf_write,
    input  logic              dout_en,
    output logic [DATA_W-1:0] op1_bus,
    output logic [DATA_W-1:0] op2_bus,
    output logic [DATA_W-1:0] res_bus,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [7:0]        opcode,
    output logic              cond_match
);
    localparam int OP1_SRCS = 2;
    localparam int OP2_SRCS = 3;
    localparam int RES_SRCS = 2;

    instr_t ir_q;
    word_t  pc_q, res_q, addr_q, din_q, disp_q;
    flags_t cc_q;
    word_t  rf_rd1, rf_rd2, alu_y;
    flags_t alu_fl;
    logic [RF_AW-1:0] port2_addr;

    // storage elements with load enables
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q   <= '0;
            pc_q   <= '0;
            cc_q   <= '0;
            res_q  <= '0;
            addr_q <= '0;
            din_q  <= '0;
            disp_q <= '0;
        end else begin
            if (ir_load)        ir_q   <= instr_t'(mem_rdata);
            if (pc_load)        pc_q   <= res_bus;
            if (cc_load)        cc_q   <= alu_fl;
            if (res_latch_load) res_q  <= res_bus;
            if (addr_load)      addr_q <= res_bus;
            if (din_load)       din_q  <= mem_rdata;
            if (disp_load)      disp_q <= mem_rdata;
        end
    end

    assign port2_addr = a2_from_r3 ? ir_q.rc : ir_q.rb;

    dp_regfile #(.W(DATA_W), .AW(RF_AW)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_write),
        .waddr  (ir_q.rc),
        .wdata  (res_q),
        .raddr1 (ir_q.ra),
        .raddr2 (port2_addr),
        .rdata1 (rf_rd1),
        .rdata2 (rf_rd2)
    );

    dp_bus_mux #(.N(OP1_SRCS), .W(DATA_W)) u_op1 (
        .clk (clk), .rst (rst), .en (op1_en),
        .src ({pc_q, rf_rd1}),
        .bus (op1_bus)
    );

    dp_bus_mux #(.N(OP2_SRCS), .W(DATA_W)) u_op2 (
        .clk (clk), .rst (rst), .en (op2_en),
        .src ({disp_q, sext_field(ir_q.rb), rf_rd2}),
        .bus (op2_bus)
    );

    dp_alu u_alu (
        .fn (alu_fn_e'(alu_func)),
        .a  (op1_bus),
        .b  (op2_bus),
        .y  (alu_y),
        .fl (alu_fl)
    );

    dp_bus_mux #(.N(RES_SRCS), .W(DATA_W)) u_res (
        .clk (clk), .rst (rst), .en (res_en),
        .src ({din_q, alu_y}),
        .bus (res_bus)
    );

    dp_cond u_cond (
        .cc    (cc_q),
        .mask  (ir_q.rc[MASK_W-1:0]),
        .match (cond_match)
    );

    assign mem_addr  = addr_q;
    assign mem_wdata = dout_en ? op2_bus : '0;
    assign opcode    = ir_q.opcode;

    // R5: PC takes the result bus value on a load
    assert_pc_load_R5: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (op1_en != 2'b10) || (op1_bus == $past(res_bus)));

    // R7: flags and hence the condition test hold without cc_load
    assert_cc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!cc_load && !ir_load) |=> $stable(cond_match));

    // R9: address latch captures the result bus
    assert_addr_latch_R9: assert property (@(posedge clk) disable iff (rst)
        addr_load |=> (mem_addr == $past(res_bus)));

endmodule

// File: tb/tri_bus_datapath_test.sv
`timescale 1ns/1ps
module tri_bus_datapath_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] mem_rdata;
    logic        ir_load, din_load, disp_load, addr_load;
    logic [1:0]  op1_en;
    logic [2:0]  op2_en;
    logic [1:0]  res_en;
    logic        a2_from_r3;
    logic [3:0]  alu_func;
    logic        cc_load, pc_load, res_latch_load, rf_write, dout_en;
    logic [31:0] op1_bus, op2_bus, res_bus, mem_addr, mem_wdata;
    logic [7:0]  opcode;
    logic        cond_match;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    tri_bus_datapath uut (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata),
        .ir_load(ir_load), .din_load(din_load), .disp_load(disp_load),
        .addr_load(addr_load), .op1_en(op1_en), .op2_en(op2_en),
        .res_en(res_en), .a2_from_r3(a2_from_r3), .alu_func(alu_func),
        .cc_load(cc_load), .pc_load(pc_load), .res_latch_load(res_latch_load),
        .rf_write(rf_write), .dout_en(dout_en), .op1_bus(op1_bus),
        .op2_bus(op2_bus), .res_bus(res_bus), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .opcode(opcode), .cond_match(cond_match)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ir_load = 0; din_load = 0; disp_load = 0; addr_load = 0;
        op1_en = 0; op2_en = 0; res_en = 0; a2_from_r3 = 0; alu_func = 0;
        cc_load = 0; pc_load = 0; res_latch_load = 0; rf_write = 0; dout_en = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic set_ir(input logic [7:0] op, input logic [7:0] rc,
                          input logic [7:0] ra, input logic [7:0] rb);
        mem_rdata = {op, rc, ra, rb};
        ir_load = 1; step(); ir_load = 0;
    endtask

    task automatic load_din(input logic [31:0] v);
        mem_rdata = v; din_load = 1; step(); din_load = 0;
    endtask

    task automatic write_reg(input logic [7:0] idx, input logic [31:0] v);
        set_ir(8'h00, idx, 8'h00, 8'h00);
        load_din(v);
        res_en = 2'b10; res_latch_load = 1; step(); res_latch_load = 0;
        rf_write = 1; step(); rf_write = 0; res_en = 0;
    endtask

    function automatic logic [35:0] model(input logic [3:0] fn, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] y; logic v;
        v = 0;
        case (fn)
            4'd0: begin y = a + b; v = (a[31] == b[31]) && (y[31] != a[31]); end
            4'd1: begin y = a - b; v = (a[31] != b[31]) && (y[31] != a[31]); end
            4'd2: y = a & b;
            4'd3: y = a | b;
            4'd4: y = a ^ b;
            4'd5: y = a & ~b;
            4'd6: y = a;
            default: y = b;
        endcase
        return {1'b0, v, y[31], (y == 0), y};
    endfunction

    task automatic t_reset();
        rst = 1; idle(); mem_rdata = 0; step(); step(); rst = 0;
        op1_en = 2'b10; #1;
        check("R1 pc cleared", op1_bus, 0);
        op1_en = 0;
        check("R1 addr cleared", mem_addr, 0);
        check("R1 opcode cleared", {24'd0, opcode}, 0);
        check("R1 flags clear, mask 0", {31'd0, cond_match}, 0);
    endtask

    task automatic t_idle_bus();
        idle(); #1;
        check("R10 op1 idle", op1_bus, 0);
        check("R10 op2 idle", op2_bus, 0);
        check("R10 res idle", res_bus, 0);
    endtask

    task automatic t_ir();
        set_ir(8'hA5, 8'h00, 8'h00, 8'h00);
        check("R11 opcode", {24'd0, opcode}, 32'hA5);
    endtask

    task automatic t_regfile();
        write_reg(8'd3, 32'hDEAD_BEEF);
        write_reg(8'd200, 32'h1234_5678);
        set_ir(8'h00, 8'h00, 8'd3, 8'h00);
        op1_en = 2'b01; #1;
        check("R2 read r3 on port1", op1_bus, 32'hDEAD_BEEF);
        op1_en = 0;
        set_ir(8'h00, 8'h00, 8'd200, 8'h00);
        op1_en = 2'b01; #1;
        check("R2 read high index", op1_bus, 32'h1234_5678);
        op1_en = 0;
    endtask

    task automatic t_port2_select();
        write_reg(8'd5, 32'hAAAA_0005);
        write_reg(8'd9, 32'h5555_0009);
        set_ir(8'h00, 8'd9, 8'h00, 8'd5);
        op2_en = 3'b001; a2_from_r3 = 0; #1;
        check("R3 port2 from rb", op2_bus, 32'hAAAA_0005);
        a2_from_r3 = 1; #1;
        check("R3 port2 from rc", op2_bus, 32'h5555_0009);
        a2_from_r3 = 0; op2_en = 0;
    endtask

    task automatic t_immediate();
        set_ir(8'h00, 8'h00, 8'h00, 8'h85);
        op2_en = 3'b010; #1;
        check("R4 negative imm", op2_bus, 32'hFFFF_FF85);
        op2_en = 0;
        set_ir(8'h00, 8'h00, 8'h00, 8'h7F);
        op2_en = 3'b010; #1;
        check("R4 positive imm", op2_bus, 32'h0000_007F);
        op2_en = 0;
    endtask

    task automatic t_pc();
        load_din(32'h0000_4000);
        res_en = 2'b10; pc_load = 1; step(); pc_load = 0; res_en = 0;
        op1_en = 2'b10; #1;
        check("R5 pc loaded", op1_bus, 32'h0000_4000);
        op1_en = 0;
        load_din(32'h0000_9999);
        res_en = 2'b10; step(); res_en = 0;
        op1_en = 2'b10; #1;
        check("R5 pc holds", op1_bus, 32'h0000_4000);
        op1_en = 0;
    endtask

    task automatic t_alu(input logic [3:0] fn, input logic [31:0] a, input logic [31:0] b);
        logic [35:0] e;
        e = model(fn, a, b);
        write_reg(8'd1, a);
        write_reg(8'd2, b);
        set_ir(8'h00, 8'h00, 8'd1, 8'd2);
        op1_en = 2'b01; op2_en = 3'b001; res_en = 2'b01; alu_func = fn; #1;
        check("R6 alu result", res_bus, e[31:0]);
        cc_load = 1; step(); cc_load = 0;
        op1_en = 0; op2_en = 0; res_en = 0;
        set_ir(8'h00, 8'h01, 8'd1, 8'd2);
        check("R7 Z flag", {31'd0, cond_match}, {31'd0, e[32]});
        set_ir(8'h00, 8'h02, 8'd1, 8'd2);
        check("R7 N flag", {31'd0, cond_match}, {31'd0, e[33]});
        set_ir(8'h00, 8'h04, 8'd1, 8'd2);
        check("R7 V flag", {31'd0, cond_match}, {31'd0, e[34]});
        set_ir(8'h00, 8'h0F, 8'd1, 8'd2);
        check("R8 inverted any", {31'd0, cond_match}, {31'd0, ~(|e[34:32])});
    endtask

    task automatic t_cc_hold();
        // flags from t_alu sub of equal values: only Z set
        set_ir(8'h00, 8'h01, 8'd1, 8'd2);
        op1_en = 2'b01; op2_en = 3'b010; alu_func = 4'd0; step();
        op1_en = 0; op2_en = 0;
        check("R7 flags hold", {31'd0, cond_match}, 1);
        set_ir(8'h00, 8'h08, 8'd1, 8'd2);
        check("R8 mask 8 alone", {31'd0, cond_match}, 1);
        set_ir(8'h00, 8'h09, 8'd1, 8'd2);
        check("R8 inverted Z", {31'd0, cond_match}, 0);
    endtask

    task automatic t_memory();
        load_din(32'hCAFE_0010);
        res_en = 2'b10; #1;
        check("R9 din on res", res_bus, 32'hCAFE_0010);
        addr_load = 1; step(); addr_load = 0; res_en = 0;
        check("R9 address latch", mem_addr, 32'hCAFE_0010);
        mem_rdata = 32'h0000_0FF0; disp_load = 1; step(); disp_load = 0;
        op2_en = 3'b100; #1;
        check("R9 disp on op2", op2_bus, 32'h0000_0FF0);
        check("R9 wdata released", mem_wdata, 0);
        dout_en = 1; #1;
        check("R9 wdata driven", mem_wdata, 32'h0000_0FF0);
        dout_en = 0; op2_en = 0;
    endtask

    task automatic t_reset_again();
        load_din(32'h0000_0123);
        res_en = 2'b10; pc_load = 1; step(); pc_load = 0; res_en = 0;
        rst = 1; step(); rst = 0;
        op1_en = 2'b10; #1;
        check("R1 pc cleared again", op1_bus, 0);
        op1_en = 0;
        set_ir(8'h00, 8'h08, 8'h00, 8'h00);
        check("R1 flags cleared", {31'd0, cond_match}, 1);
    endtask

    initial begin
        idle(); mem_rdata = 0; rst = 1;
        @(negedge clk);
        t_reset();
        t_idle_bus();
        t_ir();
        t_regfile();
        t_port2_select();
        t_immediate();
        t_pc();
        t_alu(4'd0, 32'h7FFF_FFFF, 32'h0000_0001);
        t_alu(4'd1, 32'h8000_0000, 32'h0000_0001);
        t_alu(4'd1, 32'h0000_0003, 32'h0000_0007);
        t_alu(4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00);
        t_alu(4'd3, 32'h0000_0000, 32'h0000_0000);
        t_alu(4'd4, 32'hFFFF_0000, 32'h0F0F_0F0F);
        t_alu(4'd5, 32'hFFFF_FFFF, 32'h0000_FFFF);
        t_alu(4'd6, 32'h8765_4321, 32'h1111_1111);
        t_alu(4'd9, 32'h1111_1111, 32'h8000_0000);
        t_alu(4'd1, 32'h2222_2222, 32'h2222_2222);
        t_cc_hold();
        t_memory();
        t_reset_again();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule